// File: doc/BRIEF.md
# I2C Transfer Byte Countdown Controller

This block keeps track of how many data bytes are still owed in an I2C transfer driven by a master or transmitter, and tells the bus sequencer when to close the transfer with a STOP. Software programs a 16-bit byte count into a holding register. When a transfer starts, that value is copied into a separate 17-bit working counter. Only the working counter moves, so the programmed value stays intact for the next transfer.

The shift logic sends one strobe for each completed data byte. Each strobe reduces the working counter by one. When the last byte is counted, a sticky completion flag rises. If a STOP was requested, the sequencer also receives a single-cycle request to generate the STOP condition. A programmed count of zero stands for the largest transfer, 65536 bytes. In repeat mode the count plays no part: strobes do not reduce the counter and the transfer never ends by countdown. The number of bytes still to go is brought out so the sequencer can see how far the transfer has progressed.

Top module: `bytecnt_top`

## Requirements
- R1: After reset the programmed register reads 0, the remaining count is 0, and both the completion flag and the STOP request are low.
- R2: A write strobe stores the 16-bit write data in the programmed register, and the value is visible on the read port one cycle later. Counting never changes the programmed register.
- R3: A transfer start loads the remaining count from the programmed register, visible one cycle later. Each byte strobe accepted during an active transfer then lowers the remaining count by exactly one.
- R4: A programmed value of 0x0000 loads a remaining count of 65536 (17'h10000). Values 1 to 65535 load the same number.
- R5: The completion flag rises on the clock edge at which the strobe for the last byte brings the remaining count from 1 to 0. It stays high until the next transfer start clears it.
- R6: On the edge where the count completes, the STOP request pulses high for exactly one cycle if the STOP-request input is high on that edge. Otherwise it stays low.
- R7: While the repeat-mode input is high, byte strobes leave the remaining count unchanged, and neither the completion flag nor the STOP request is raised.
- R8: Byte strobes that arrive when no transfer is active are ignored: the remaining count stays at 0 and never wraps. This covers strobes before any start and strobes after the count has completed.
- R9: A write to the programmed register during an active transfer leaves the running count untouched. The new value is used from the next transfer start.
- R10: When a transfer start and a byte strobe arrive in the same cycle, the start wins. The count is loaded in full and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntWrEn | input | 1 | Write strobe for the programmed count register |
| cntWrData | input | 16 | Write data for the programmed count register |
| cntRdData | output | 16 | Programmed count register read value |
| xferStart | input | 1 | Transfer start pulse; loads the working counter |
| byteDone | input | 1 | One-cycle strobe per data byte transferred |
| repeatMode | input | 1 | High bypasses counting |
| stopReq | input | 1 | High requests a STOP when the countdown finishes |
| countDone | output | 1 | Sticky countdown-complete flag |
| genStop | output | 1 | One-cycle request to generate a STOP condition |
| bytesLeft | output | 17 | Bytes remaining in the current transfer |

## Verification
The hardest case to reach from the ports is a zero count: it runs the full 65536-byte countdown, with the working counter holding a value its 16-bit register cannot hold. The stimulus programs zero, starts a transfer, and sends a byte strobe on every cycle until completion, so the run fits within the cycle limit. A reference model in the bench follows each of those cycles, so the whole descent is compared and not only its end. Strobes that arrive after completion, and a start and a strobe that collide in one cycle, are driven on purpose right at the boundary between two transfers.

// File: rtl/bytecnt_pkg.sv
package bytecnt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // copy programmed value into working counter
    logic dec;   // subtract one from working counter
  } dpCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctlState_t;
endpackage

// File: rtl/bytecnt_datapath.sv
module bytecnt_datapath
  import bytecnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] regValue,
  output logic [CNT_W:0]   remaining,
  output logic             atOne
);
  localparam int CTR_W = CNT_W + 1;
  localparam logic [CTR_W-1:0] FULL_LOAD = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CTR_W-1:0] ONE       = CTR_W'(1);

  logic [CNT_W-1:0] progReg;
  logic [CTR_W-1:0] workCtr;
  logic [CTR_W-1:0] loadVal;

  always_comb begin
    if (progReg == '0) loadVal = FULL_LOAD;
    else               loadVal = {1'b0, progReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) progReg <= '0;
    else if (regWrEn) progReg <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         workCtr <= '0;
    else if (cmd.load) workCtr <= loadVal;
    else if (cmd.dec)  workCtr <= workCtr - ONE;
  end

  assign regValue  = progReg;
  assign remaining = workCtr;
  assign atOne     = (workCtr == ONE);
endmodule

// File: rtl/bytecnt_ctrl.sv
module bytecnt_ctrl
  import bytecnt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   xferStart,
  input  logic   byteDone,
  input  logic   repeatMode,
  input  logic   stopReq,
  input  logic   atOne,
  output dpCmd_t cmd,
  output logic   countDone,
  output logic   genStop
);
  ctlState_t state, stateNxt;
  logic      finish;

  always_comb begin
    cmd.load = xferStart;
    cmd.dec  = byteDone && !xferStart && !repeatMode && (state == ST_RUN);
    finish   = cmd.dec && atOne;
  end

  always_comb begin
    stateNxt = state;
    if (xferStart)   stateNxt = ST_RUN;
    else if (finish) stateNxt = ST_FIN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      countDone <= 1'b0;
      genStop   <= 1'b0;
    end else begin
      state   <= stateNxt;
      genStop <= finish && stopReq;
      if (xferStart)   countDone <= 1'b0;
      else if (finish) countDone <= 1'b1;
    end
  end
endmodule

// File: rtl/bytecnt_top.sv
module bytecnt_top
  import bytecnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntRdData,
  input  logic             xferStart,
  input  logic             byteDone,
  input  logic             repeatMode,
  input  logic             stopReq,
  output logic             countDone,
  output logic             genStop,
  output logic [CNT_W:0]   bytesLeft
);
  dpCmd_t cmd;
  logic   atOne;

  bytecnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .byteDone(byteDone),
    .repeatMode(repeatMode), .stopReq(stopReq), .atOne(atOne),
    .cmd(cmd), .countDone(countDone), .genStop(genStop)
  );

  bytecnt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(cntWrEn), .regWrData(cntWrData),
    .cmd(cmd), .regValue(cntRdData), .remaining(bytesLeft), .atOne(atOne)
  );
endmodule

// File: rtl/bytecnt_checker.sv
module bytecnt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntRdData,
  input logic             xferStart,
  input logic             repeatMode,
  input logic             stopReq,
  input logic             countDone,
  input logic             genStop,
  input logic [CNT_W:0]   bytesLeft
);
  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cntWrEn) |-> $stable(cntRdData));
  // R3
  no_climb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(xferStart) |-> (bytesLeft <= $past(bytesLeft)));
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(countDone) |-> $past(xferStart));
  // R5
  done_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    countDone |-> (bytesLeft == '0));
  // R6
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    genStop |-> ($rose(countDone) && $past(stopReq)));
  // R6
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    genStop |=> !genStop);
  // R7
  repeat_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(repeatMode) && !$past(xferStart)) |-> ($stable(bytesLeft) && !genStop));
endmodule

bind bytecnt_top bytecnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntRdData(cntRdData),
  .xferStart(xferStart), .repeatMode(repeatMode), .stopReq(stopReq),
  .countDone(countDone), .genStop(genStop), .bytesLeft(bytesLeft)
);

// File: tb/tb_bytecnt_top.sv
module tb_bytecnt_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cntWrEn, xferStart, byteDone, repeatMode, stopReq;
  logic [15:0] cntWrData, cntRdData;
  logic        countDone, genStop;
  logic [16:0] bytesLeft;

  always #2 clk = ~clk;  // 250 MHz

  bytecnt_top dut (
    .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntRdData(cntRdData), .xferStart(xferStart), .byteDone(byteDone),
    .repeatMode(repeatMode), .stopReq(stopReq), .countDone(countDone),
    .genStop(genStop), .bytesLeft(bytesLeft)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model
  logic [15:0] mReg;
  logic [16:0] mCtr;
  logic        mDone, mStop, mActive;
  string       curTag;

  string       tagQ[$];
  logic [34:0] expQ[$];  // {done, stop, left[16:0], rd[15:0]}

  task automatic pushExp();
    tagQ.push_back(curTag);
    expQ.push_back({mDone, mStop, mCtr, mReg});
  endtask

  task automatic cyc(input logic st, input logic bd, input logic wr,
                     input logic [15:0] wd, input logic rep, input logic sp);
    @(negedge clk);
    xferStart = st; byteDone = bd; cntWrEn = wr; cntWrData = wd;
    repeatMode = rep; stopReq = sp;
    @(posedge clk);
    #1;
    mStop = 1'b0;
    if (st) begin
      mCtr = (mReg == 16'h0) ? 17'h10000 : {1'b0, mReg};
      mDone = 1'b0;
      mActive = 1'b1;
    end else if (bd && mActive && !rep) begin
      if (mCtr == 17'd1) begin
        mDone = 1'b1;
        mActive = 1'b0;
        mStop = sp;
      end
      mCtr = mCtr - 17'd1;
    end
    if (wr) mReg = wd;
    pushExp();
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        string       t;
        logic [34:0] e;
        logic [34:0] a;
        t = tagQ.pop_front();
        e = expQ.pop_front();
        a = {countDone, genStop, bytesLeft, cntRdData};
        tests++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: done/stop/left/rd actual %b/%b/%0d/%h expected %b/%b/%0d/%h",
                   t, a[34], a[33], a[32:16], a[15:0], e[34], e[33], e[32:16], e[15:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0;
    cntWrEn = 0; cntWrData = 0; xferStart = 0; byteDone = 0;
    repeatMode = 0; stopReq = 0;
    mReg = 0; mCtr = 0; mDone = 0; mStop = 0; mActive = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    curTag = "R1 reset state";
    pushExp();

    // R8: strobes before any start are ignored
    curTag = "R8 idle strobes";
    repeat (3) cyc(0, 1, 0, 0, 0, 1);

    // R2: write and read back
    curTag = "R2 write";
    cyc(0, 0, 1, 16'd3, 0, 0);

    // R3/R5/R6: three-byte transfer with STOP
    curTag = "R3 load";
    cyc(1, 0, 0, 0, 0, 1);
    curTag = "R3 countdown";
    cyc(0, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 1);
    curTag = "R6 stop pulse / R5 done";
    cyc(0, 1, 0, 0, 0, 1);
    curTag = "R5 done sticky R6 single pulse";
    cyc(0, 0, 0, 0, 0, 1);
    // R8: strobes after completion ignored, no wrap
    curTag = "R8 late strobes";
    repeat (4) cyc(0, 1, 0, 0, 0, 1);

    // R6: completion without STOP request
    curTag = "R6 no stop";
    cyc(1, 0, 0, 0, 0, 0);
    repeat (3) cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R7: repeat mode bypasses counting
    curTag = "R7 repeat";
    cyc(0, 0, 1, 16'd2, 0, 1);
    cyc(1, 0, 0, 0, 1, 1);
    repeat (5) cyc(0, 1, 0, 0, 1, 1);
    curTag = "R7 leave repeat";
    cyc(0, 1, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 1);

    // R9: write during active transfer
    curTag = "R9 write mid-transfer";
    cyc(0, 0, 1, 16'd5, 0, 1);
    cyc(1, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 1);
    cyc(0, 1, 1, 16'd10, 0, 1);
    repeat (3) cyc(0, 1, 0, 0, 0, 1);
    curTag = "R9 new value at next start";
    cyc(1, 0, 0, 0, 0, 1);

    // R10: start and strobe in same cycle
    curTag = "R10 start beats strobe";
    cyc(0, 1, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R4: zero means 65536
    curTag = "R4 zero load";
    cyc(0, 0, 1, 16'h0000, 0, 1);
    cyc(1, 0, 0, 0, 0, 1);
    curTag = "R4 full countdown";
    repeat (65536) cyc(0, 1, 0, 0, 0, 1);
    curTag = "R4 after full countdown";
    cyc(0, 1, 0, 0, 0, 1);

    // R2: max value loads as-is
    curTag = "R2 max value";
    cyc(0, 0, 1, 16'hFFFF, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule